// File: doc/BRIEF.md
# Segmented Shared-Line Bus Cycle Controller

This block sits between a processor core and a bus whose address and data travel on the same wires. The core hands it one request at a time: a 16-bit segment, a 16-bit offset, a memory/I/O choice, a read/write choice, a byte/word size and write data. The block computes the 20-bit physical address, places it on the shared lines for one clock while pulsing an address-latch strobe, and then either drives write data or releases the lines and samples read data during the rest of the cycle.

A transfer with no wait states always takes four clocks (T1 to T4). A slow target holds the ready input low at the end of T3 to stretch the cycle with wait clocks. When the data phase ends, the block returns a one-clock done pulse and, for reads, the captured data. A new request may enter while the controller is idle or in the final clock of the current cycle, so accesses can run back to back with no gap.

Top module: `busctl_top`

## Requirements
- R1: For a memory access, the lines in T1 carry (segment × 16 + offset) modulo 2^20; any carry out of bit 19 is dropped, and different segment:offset pairs naming the same location give the same value.
- R2: For an I/O access, the lines in T1 carry the offset zero-extended to 20 bits, the segment has no effect, and `bus_io` is 1 from T1 to T4 (0 for memory).
- R3: `bus_ale` is 1 only in T1, for exactly one clock per access, and `bus_ad_oe` is 1 in T1.
- R4: For a read, `bus_ad_oe` is 0 from T2 to T4, `bus_rd_n` is 0 in T2, T3 and every wait clock, and 1 in T1 and T4.
- R5: For a write, `bus_ad_oe` is 1 from T2 to T4 with the write data on bits 15:0 of the lines; a byte write (`req_word` = 0) places bits 7:0 of the data with bits 15:8 forced to 0; `bus_wr_n` is 0 in T2, T3 and every wait clock.
- R6: With ready held high, `rsp_done` is 1 in the fourth clock after the accepting edge (T4) and for that one clock only.
- R7: Ready sampled low at the end of T3 inserts one wait clock for every clock it stays low; T4 follows the first clock edge where ready is high.
- R8: Read data is captured from bits 15:0 of `bus_ad_in` at the edge that enters T4 and shown on `rsp_rdata` while `rsp_done` is 1; a byte read returns bits 7:0 with bits 15:8 set to 0.
- R9: `req_accept` is 1 only when idle or in T4; a request presented while it is 0 is ignored, and a request taken in T4 starts T1 on the next clock.
- R10: A synchronous active-high `rst` returns the controller to idle: strobes inactive, lines released, no done pulse, `req_accept` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core presents a request |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset, or port number for I/O |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Request taken this clock when req_valid is 1 |
| bus_ad_out | output | 20 | Value driven onto the shared lines |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 16 | Value sampled from the shared lines |
| bus_ale | output | 1 | Address-latch strobe, high in T1 |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io | output | 1 | 1 during an I/O cycle |
| bus_word | output | 1 | 1 during a 16-bit cycle |
| bus_ready | input | 1 | Target ready; low at end of T3 adds waits |
| rsp_done | output | 1 | One-clock completion pulse in T4 |
| rsp_rdata | output | 16 | Captured read data |

## Verification
A table of accesses covers memory reads and writes with ordinary, wrapping (carry past bit 19) and top-of-space addresses, an aliased segment:offset pair, and I/O reads and writes with a nonzero segment, so address forming is told apart from a plain concatenation, from a version that keeps the carry and from one that adds the segment to port numbers. Byte and word sizes are mixed so that upper-byte masking on both data directions shows up, and wait counts of zero to three separate the sampling point of ready from a fixed-length cycle. Directed sequences chain two accesses through T4, present a request while the controller is busy, and apply reset in mid-cycle.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bstate_t;

  typedef struct packed {
    logic io;
    logic wr;
    logic word;
  } bctl_t;
endpackage

// File: rtl/busctl_agen.sv
module busctl_agen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic              io,
  output logic [ADDR_W-1:0] phys
);
  localparam int SHIFT = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] seg_base;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    seg_base = ADDR_W'(seg) << SHIFT;
    off_ext  = ADDR_W'(off);
    // Sum is truncated to ADDR_W bits: carry past the top bit is lost.
    phys     = io ? off_ext : (seg_base + off_ext);
  end
endmodule

// File: rtl/busctl_fsm.sv
module busctl_fsm
  import busctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    ready,
  output bstate_t state,
  output logic    accept,
  output logic    fire,
  output logic    capture
);
  bstate_t nxt;

  always_comb begin
    accept  = (state == ST_IDLE) || (state == ST_T4);
    fire    = accept && req_valid;
    capture = ((state == ST_T3) || (state == ST_TW)) && ready;
    case (state)
      ST_IDLE: nxt = fire ? ST_T1 : ST_IDLE;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3:   nxt = ready ? ST_T4 : ST_TW;
      ST_TW:   nxt = ready ? ST_T4 : ST_TW;
      ST_T4:   nxt = fire ? ST_T1 : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/busctl_dpath.sv
module busctl_dpath
  import busctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  bstate_t           state,
  input  logic              fire,
  input  logic              capture,
  input  logic [ADDR_W-1:0] phys,
  input  bctl_t             ctl_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io,
  output logic              word,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'({BYTE_W{1'b1}});

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  bctl_t             ctl_q;
  logic              in_data;
  logic              strobe_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      ctl_q   <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      if (fire) begin
        addr_q  <= phys;
        ctl_q   <= ctl_in;
        wdata_q <= ctl_in.word ? wdata : (wdata & LOW_MASK);
      end
      done <= capture;
      if (capture && !ctl_q.wr)
        rdata <= ctl_q.word ? ad_in : (ad_in & LOW_MASK);
    end
  end

  always_comb begin
    in_data    = (state == ST_T2) || (state == ST_T3) ||
                 (state == ST_TW) || (state == ST_T4);
    strobe_win = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
    ale        = (state == ST_T1);
    ad_oe      = ale || (in_data && ctl_q.wr);
    ad_out     = ale ? addr_q : ((in_data && ctl_q.wr) ? ADDR_W'(wdata_q) : '0);
    rd_n       = !(strobe_win && !ctl_q.wr);
    wr_n       = !(strobe_win && ctl_q.wr);
    io         = (state != ST_IDLE) && ctl_q.io;
    word       = (state != ST_IDLE) && ctl_q.word;
  end
endmodule

// File: rtl/busctl_top.sv
module busctl_top
  import busctl_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_io,
  input  logic              req_wr,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_accept,
  output logic [ADDR_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_io,
  output logic              bus_word,
  input  logic              bus_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  bstate_t           state;
  logic              fire;
  logic              capture;
  logic [ADDR_W-1:0] phys;
  bctl_t             ctl_in;

  assign ctl_in = '{io: req_io, wr: req_wr, word: req_word};

  busctl_agen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_agen (
    .seg (req_seg),
    .off (req_off),
    .io  (req_io),
    .phys(phys)
  );

  busctl_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .ready    (bus_ready),
    .state    (state),
    .accept   (req_accept),
    .fire     (fire),
    .capture  (capture)
  );

  busctl_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .state  (state),
    .fire   (fire),
    .capture(capture),
    .phys   (phys),
    .ctl_in (ctl_in),
    .wdata  (req_wdata),
    .ad_in  (bus_ad_in),
    .ad_out (bus_ad_out),
    .ad_oe  (bus_ad_oe),
    .ale    (bus_ale),
    .rd_n   (bus_rd_n),
    .wr_n   (bus_wr_n),
    .io     (bus_io),
    .word   (bus_word),
    .done   (rsp_done),
    .rdata  (rsp_rdata)
  );
endmodule

// File: rtl/busctl_chk.sv
module busctl_chk (
  input logic clk,
  input logic rst,
  input logic bus_ale,
  input logic bus_ad_oe,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic rsp_done,
  input logic req_accept
);
  // R3
  ale_drives_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> bus_ad_oe);
  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale);
  // R4
  rd_released_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (!bus_ad_oe && bus_wr_n && !bus_ale));
  // R5
  wr_drives_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> (bus_ad_oe && bus_rd_n && !bus_ale));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R8
  done_strobes_off_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (bus_rd_n && bus_wr_n && !bus_ale));
  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ale || !bus_rd_n || !bus_wr_n) |-> !req_accept);
  // R9
  done_accept_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_accept);
endmodule

bind busctl_top busctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_ale   (bus_ale),
  .bus_ad_oe (bus_ad_oe),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .rsp_done  (rsp_done),
  .req_accept(req_accept)
);

// File: tb/busctl_top_test.sv
`timescale 1ns/1ps
module busctl_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic        req_io = 1'b0;
  logic        req_wr = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_accept;
  logic [19:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic        bus_ale;
  logic        bus_rd_n;
  logic        bus_wr_n;
  logic        bus_io;
  logic        bus_word;
  logic        bus_ready = 1'b1;
  logic        rsp_done;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  busctl_top uut (.*);

  typedef struct packed {
    logic [15:0] seg;
    logic [15:0] off;
    logic        io;
    logic        wr;
    logic        word;
    logic [15:0] wdata;
    logic [15:0] rdin;
    logic [3:0]  waits;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{16'h1234, 16'h5678, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 4'd0},
    '{16'hFFFF, 16'h0010, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hA5C3, 4'd1},
    '{16'hF000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'h1357, 16'h0000, 4'd0},
    '{16'h0ABC, 16'h1234, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h4242, 4'd2},
    '{16'h0ABC, 16'h00FF, 1'b1, 1'b1, 1'b0, 16'h9A7E, 16'h0000, 4'd0},
    '{16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h00FF, 16'h0000, 4'd3},
    '{16'h0FFF, 16'h0010, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0102, 4'd0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R6 done low after T4", 32'(rsp_done), 32'd0);
    check("R9 no new T1", 32'(bus_ale), 32'd0);
    check("R10 idle lines released", 32'(bus_ad_oe), 32'd0);
  endtask

  // Issues one access from a negedge where req_accept is expected high;
  // returns at the negedge inside T4.
  task automatic run_acc(vec_t v, bit poke);
    int ea;
    logic [15:0] exp_wd;
    logic [15:0] exp_rd;
    ea = v.io ? int'(v.off) : ((int'(v.seg) * 16 + int'(v.off)) % 1048576);
    exp_wd = v.word ? v.wdata : {8'h00, v.wdata[7:0]};
    exp_rd = v.word ? v.rdin  : {8'h00, v.rdin[7:0]};
    check("R9 accept ready", 32'(req_accept), 32'd1);
    req_seg = v.seg; req_off = v.off; req_io = v.io; req_wr = v.wr;
    req_word = v.word; req_wdata = v.wdata; bus_ad_in = v.rdin;
    req_valid = 1'b1;
    @(negedge clk); // T1
    req_valid = 1'b0;
    req_seg = 16'hDEAD; req_off = 16'hBEEF; req_wdata = 16'hCAFE;
    check("R3 ale in T1", 32'(bus_ale), 32'd1);
    check("R3 oe in T1", 32'(bus_ad_oe), 32'd1);
    if (v.io) check("R2 io port address", 32'(bus_ad_out), 32'(ea));
    else      check("R1 physical address", 32'(bus_ad_out), 32'(ea));
    check("R2 io flag", 32'(bus_io), 32'(v.io));
    check("R4 strobes idle in T1", 32'({bus_rd_n, bus_wr_n}), 32'd3);
    check("R9 busy in T1", 32'(req_accept), 32'd0);
    @(negedge clk); // T2
    bus_ready = (v.waits == 0);
    if (poke) begin
      req_seg = 16'h4444; req_off = 16'h5555; req_valid = 1'b1;
    end
    check("R3 ale low in T2", 32'(bus_ale), 32'd0);
    if (v.wr) begin
      check("R5 write drive", 32'(bus_ad_oe), 32'd1);
      check("R5 write data", 32'(bus_ad_out), 32'(exp_wd));
      check("R5 wr strobe", 32'({bus_rd_n, bus_wr_n}), 32'd2);
    end else begin
      check("R4 read release", 32'(bus_ad_oe), 32'd0);
      check("R4 rd strobe", 32'({bus_rd_n, bus_wr_n}), 32'd1);
    end
    @(negedge clk); // T3
    req_valid = 1'b0;
    check("R6 no done in T3", 32'(rsp_done), 32'd0);
    check("R9 busy in T3", 32'(req_accept), 32'd0);
    for (int i = 0; i < int'(v.waits); i++) begin
      @(negedge clk); // wait clock
      check("R7 no done during wait", 32'(rsp_done), 32'd0);
      check("R7 strobe held during wait", 32'(v.wr ? bus_wr_n : bus_rd_n), 32'd0);
      if (i == int'(v.waits) - 1) bus_ready = 1'b1;
    end
    @(negedge clk); // T4
    check("R6 done in T4", 32'(rsp_done), 32'd1);
    check("R4 strobes off in T4", 32'({bus_rd_n, bus_wr_n}), 32'd3);
    if (v.wr) check("R5 write data held T4", 32'(bus_ad_out), 32'(exp_wd));
    else begin
      check("R8 read data", 32'(rsp_rdata), 32'(exp_rd));
      check("R4 released in T4", 32'(bus_ad_oe), 32'd0);
    end
    check("R9 accept in T4", 32'(req_accept), 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t a;
    vec_t b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 ale", 32'(bus_ale), 32'd0);
    check("R10 oe", 32'(bus_ad_oe), 32'd0);
    check("R10 strobes", 32'({bus_rd_n, bus_wr_n}), 32'd3);
    check("R10 done", 32'(rsp_done), 32'd0);
    check("R10 accept", 32'(req_accept), 32'd1);

    foreach (VEC[k]) begin
      run_acc(VEC[k], 1'b0);
      idle_check();
    end

    // R9 back to back: second request taken in T4 of the first
    a = '{16'h2000, 16'h0004, 1'b0, 1'b1, 1'b1, 16'hA1B2, 16'h0000, 4'd0};
    b = '{16'h0000, 16'h0300, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h77E1, 4'd1};
    run_acc(a, 1'b0);
    run_acc(b, 1'b0);
    idle_check();

    // R9 request offered while busy is ignored
    run_acc(VEC[0], 1'b1);
    idle_check();

    // R10 reset in the middle of a cycle
    req_seg = 16'h1111; req_off = 16'h2222; req_io = 1'b0; req_wr = 1'b1;
    req_word = 1'b1; req_wdata = 16'h3333; req_valid = 1'b1;
    @(negedge clk); // T1
    req_valid = 1'b0;
    @(negedge clk); // T2
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid-cycle oe", 32'(bus_ad_oe), 32'd0);
    check("R10 mid-cycle wr", 32'(bus_wr_n), 32'd1);
    check("R10 mid-cycle done", 32'(rsp_done), 32'd0);
    check("R10 mid-cycle accept", 32'(req_accept), 32'd1);
    run_acc(VEC[6], 1'b0);
    idle_check();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule